// File: doc/BRIEF.md
# ISA I/O Window Decoder with Ready and Width Compatibility Modes

This block sits between the ISA bus pins and a 16-bit peripheral that occupies a 32-port I/O window. It decides whether the address on the bus belongs to the window. It reports the port offset inside the window and drives the 16-bit transfer indication for the word-wide ports. When the peripheral asks for extra time, it pulls the ready line low. The data path is handled elsewhere.

Some host chipsets sample the width and ready signals at awkward moments. Two mode inputs deal with this. The width-late mode raises the 16-bit indication only once an I/O read or write strobe is active. The early-ready mode pulls ready low while the address latch enable is still high, which is before any strobe. That early wait is dropped at once if a memory strobe turns up. If no memory strobe appears, it is held until the first falling edge of the ISA clock after the address latch enable drops. Normal strobe-based waiting then takes over. A sticky flag records any I/O strobe that ended while the peripheral still wanted more time, so that software can detect the condition.

Every ISA input is assumed to be already synchronised to `clk`. Every output is registered. Each result therefore appears on the first rising edge of `clk` after the inputs that cause it.

Top module: `isa_io_decoder`

## Requirements
- R1: With `aen` low and `base_sel` set to 0 through 6, the window base is 240h, 280h, 2C0h, 300h, 320h, 340h or 360h in that order. `cs` is 1 when `sa[9:5]` equals the upper five bits of the selected base, and `port_off` then equals `sa[4:0]`. An address 20h above the base gives `cs` = 0.
- R2: `cs` is 0 and `port_off` is 0 whenever `aen` is high, and also whenever `base_sel` is 7 (window switched off).
- R3: With both mode inputs low, `io16_n` is 0 whenever `cs` holds for a word port, meaning offsets 10h to 17h. No strobe is needed. For any other address `io16_n` is 1.
- R4: With `mode_io16` high, `io16_n` is 0 only when `cs` holds for a word port and `iord_n` or `iowr_n` is low.
- R5: `chrdy_low` is 1 when a strobe (`iord_n` or `iowr_n` low) is active on a decoded address while `need_wait` is 1. Outside the early-ready mode, `chrdy_low` is 0 in every other case, whatever `bale` does. `chrdy_low` = 1 means the ready line is pulled low. The block never drives ready high.
- R6: In early-ready mode (`mode_chrdy` = 1, `mode_io16` = 0), `chrdy_low` becomes 1 when `bale` is high on a decoded address with `need_wait` = 1, and no strobe is needed. It stays 1 after `bale` falls and drops at the first falling edge of `isaclk` seen after `bale` fell.
- R7: In early-ready mode, `mrd_n` or `mwr_n` going low ends the early wait at once. It does not restart while `bale` stays high.
- R8: When an I/O strobe on a decoded address ends while `need_wait` is still 1, `late_flag` becomes 1.
- R9: `late_flag` stays 1 until reset or a cycle with `stat_clr` = 1. A strobe that ends with `need_wait` = 0 does not set it.
- R10: With both mode inputs high, the width-late behaviour of R4 applies and the early wait of R6 is not produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sa | input | 10 | ISA I/O address |
| aen | input | 1 | DMA address enable, high blocks decoding |
| bale | input | 1 | Address latch enable |
| iord_n | input | 1 | I/O read strobe, active low |
| iowr_n | input | 1 | I/O write strobe, active low |
| mrd_n | input | 1 | Memory read strobe, active low |
| mwr_n | input | 1 | Memory write strobe, active low |
| isaclk | input | 1 | ISA bus clock, sampled as data |
| need_wait | input | 1 | Peripheral requests a longer cycle |
| base_sel | input | 3 | Window base code, 7 switches the window off |
| mode_io16 | input | 1 | Raise width indication only after a strobe |
| mode_chrdy | input | 1 | Pull ready low early, from the latch enable |
| stat_clr | input | 1 | Software write of 1 that clears the late flag |
| cs | output | 1 | Window selected |
| io16_n | output | 1 | 16-bit transfer indication, active low |
| chrdy_low | output | 1 | Pull ready line low |
| port_off | output | 5 | Port offset inside the window |
| late_flag | output | 1 | Sticky record of a strobe that ended too early |

## Verification
Each result is registered once, so every output is due one `clk` rising edge after the inputs that cause it. The bench drives inputs just after a falling edge and reads outputs at the next falling edge. That puts the one edge of latency between stimulus and sample. The `isaclk` falling edge and the `bale` falling edge are found by comparing with the previous sample. An early wait therefore ends on the edge that sees the new low level of `isaclk`, and the check is placed one falling edge after that level is driven. The late flag is checked one falling edge after the strobe is released.

// File: rtl/isa_dec_pkg.sv
// Package: shared constants, the window base table and the early-ready
// state type for the ISA I/O decoder.
// Assumes: base codes 0..6 are valid, code 7 disables the window.
package isa_dec_pkg;

    localparam int ADDR_W    = 10;
    localparam int OFS_W     = 5;
    localparam int SEL_W     = 3;
    localparam int NUM_BASES = 7;

    typedef enum logic [1:0] {
        E_IDLE  = 2'd0,
        E_HOLD  = 2'd1,
        E_ARMED = 2'd2,
        E_SPENT = 2'd3
    } early_st_t;

    // Window base address for a given selection code.
    function automatic logic [ADDR_W-1:0] base_of(input int idx);
        logic [ADDR_W-1:0] b;
        case (idx)
            0:       b = 10'h240;
            1:       b = 10'h280;
            2:       b = 10'h2C0;
            3:       b = 10'h300;
            4:       b = 10'h320;
            5:       b = 10'h340;
            default: b = 10'h360;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/isa_addr_match.sv
// Module: combinational window match. One comparator per base code is
// generated and the comparator of the selected code is used.
// Assumes: the window size is 2**OFS_W ports and is aligned to that size.
module isa_addr_match
    import isa_dec_pkg::*;
#(
    parameter int WORD_FIRST = 16,
    parameter int WORD_LAST  = 23
) (
    input  logic [ADDR_W-1:0] sa,
    input  logic              aen,
    input  logic [SEL_W-1:0]  base_sel,
    output logic              hit,
    output logic              word_hit,
    output logic [OFS_W-1:0]  offset
);
    localparam int HI_W = ADDR_W - OFS_W;

    logic [NUM_BASES-1:0] lane_hit;

    // One upper-bit comparator for each base code.
    for (genvar g = 0; g < NUM_BASES; g++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_BASE = base_of(g);
        assign lane_hit[g] = (sa[ADDR_W-1:OFS_W] == LANE_BASE[ADDR_W-1:OFS_W]);
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;

    // Pick the comparator of the selected code, with AEN blocking and code 7 off.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_BASES; i++) begin
            if (base_sel == SEL_W'(i)) hit = lane_hit[i];
        end
        if (aen) hit = 1'b0;
    end

    // Offset inside the window and word-port classification.
    always_comb begin
        offset   = hit ? sa[OFS_W-1:0] : '0;
        word_hit = hit && (int'(sa[OFS_W-1:0]) >= WORD_FIRST)
                       && (int'(sa[OFS_W-1:0]) <= WORD_LAST);
    end

endmodule

// File: rtl/isa_io16_gen.sv
// Module: registered 16-bit transfer indication (active low). In the
// standard mode it follows the word-port decode, and in the width-late mode it
// also needs an active I/O strobe.
// Assumes: inputs are synchronous to clk.
module isa_io16_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic word_hit,
    input  logic io_act,
    input  logic late_mode,
    output logic io16_n
);
    logic drive;

    // Decide whether the width indication is wanted this cycle.
    always_comb begin
        drive = word_hit && (!late_mode || io_act);
    end

    // Register the active-low output.
    always_ff @(posedge clk) begin
        if (!rst_n) io16_n <= 1'b1;
        else        io16_n <= !drive;
    end

    // R4
    io16_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        late_mode && !io_act |=> io16_n);

endmodule

// File: rtl/isa_wait_ctl.sv
// Module: ready-line control. A strobe-based wait is always produced. An
// optional early wait starts at the address latch enable, ends on a memory
// strobe, or ends at the first ISA clock fall after the latch enable falls.
// Assumes: bale and isaclk are synchronised to clk. Edges are found by
// comparing with the previous sample.
module isa_wait_ctl
    import isa_dec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic need_wait,
    input  logic io_act,
    input  logic mem_act,
    input  logic bale,
    input  logic isaclk,
    input  logic early_en,
    output logic chrdy_low
);
    early_st_t st, st_nxt;
    logic      bale_q, isaclk_q;
    logic      bale_fall, clk_fall, early_on, chrdy_d;

    // Previous samples of the latch enable and the ISA clock, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bale_q   <= 1'b0;
            isaclk_q <= 1'b0;
        end else begin
            bale_q   <= bale;
            isaclk_q <= isaclk;
        end
    end

    assign bale_fall = bale_q && !bale;
    assign clk_fall  = isaclk_q && !isaclk;

    // Next state of the early-wait sequencer.
    always_comb begin
        st_nxt = st;
        case (st)
            E_IDLE: begin
                if (early_en && bale && hit && need_wait)
                    st_nxt = mem_act ? E_SPENT : E_HOLD;
            end
            E_HOLD: begin
                if (!early_en)      st_nxt = E_IDLE;
                else if (mem_act)   st_nxt = E_SPENT;
                else if (bale_fall) st_nxt = E_ARMED;
            end
            E_ARMED: begin
                if (!early_en || mem_act || clk_fall) st_nxt = E_IDLE;
            end
            default: begin
                if (!bale) st_nxt = E_IDLE;
            end
        endcase
    end

    // Combine the early wait with the strobe-based wait.
    always_comb begin
        early_on = (st_nxt == E_HOLD) || (st_nxt == E_ARMED);
        chrdy_d  = (io_act && hit && need_wait) || early_on;
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= E_IDLE;
            chrdy_low <= 1'b0;
        end else begin
            st        <= st_nxt;
            chrdy_low <= chrdy_d;
        end
    end

    // R7
    mem_strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_act && !io_act |=> !chrdy_low);

    // R5
    no_wait_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !early_en && !io_act |=> !chrdy_low);

    // R6
    early_ends_on_isaclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_ARMED) && clk_fall && !io_act |=> !chrdy_low);

endmodule

// File: rtl/isa_late_flag.sv
// Module: sticky flag for an I/O strobe that ended while the peripheral
// still requested more time. Setting wins over a clear in the same cycle.
// Assumes: stat_clr is a one-cycle pulse from a software write of 1.
module isa_late_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic io_act,
    input  logic need_wait,
    input  logic stat_clr,
    output logic late_flag
);
    logic in_strobe_q;
    logic set_ev;

    // Remember whether a decoded I/O strobe was active in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) in_strobe_q <= 1'b0;
        else        in_strobe_q <= io_act && hit;
    end

    assign set_ev = in_strobe_q && !io_act && need_wait;

    // Sticky flag: set on an early strobe end, clear on a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n)        late_flag <= 1'b0;
        else if (set_ev)   late_flag <= 1'b1;
        else if (stat_clr) late_flag <= 1'b0;
    end

    // R9
    late_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        late_flag && !stat_clr |=> late_flag);

    // R8
    late_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> late_flag);

endmodule

// File: rtl/isa_io_decoder.sv
// Module: top of the ISA I/O window decoder. It decodes the 32-port window,
// drives the width indication and the ready pull-low with the compatibility
// modes, and keeps the late-ready flag.
// Assumes: all ISA inputs are already synchronised to clk. Strobes are active
// low. If both mode inputs are high, the width-late mode takes priority.
module isa_io_decoder
    import isa_dec_pkg::*;
#(
    parameter int WORD_FIRST = 16,
    parameter int WORD_LAST  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sa,
    input  logic              aen,
    input  logic              bale,
    input  logic              iord_n,
    input  logic              iowr_n,
    input  logic              mrd_n,
    input  logic              mwr_n,
    input  logic              isaclk,
    input  logic              need_wait,
    input  logic [SEL_W-1:0]  base_sel,
    input  logic              mode_io16,
    input  logic              mode_chrdy,
    input  logic              stat_clr,
    output logic              cs,
    output logic              io16_n,
    output logic              chrdy_low,
    output logic [OFS_W-1:0]  port_off,
    output logic              late_flag
);
    logic             hit, word_hit;
    logic [OFS_W-1:0] offset;
    logic             io_act, mem_act, early_en;

    // Strobe activity and mode priority.
    always_comb begin
        io_act   = !iord_n || !iowr_n;
        mem_act  = !mrd_n || !mwr_n;
        early_en = mode_chrdy && !mode_io16;
    end

    isa_addr_match #(
        .WORD_FIRST (WORD_FIRST),
        .WORD_LAST  (WORD_LAST)
    ) u_match (
        .sa       (sa),
        .aen      (aen),
        .base_sel (base_sel),
        .hit      (hit),
        .word_hit (word_hit),
        .offset   (offset)
    );

    // Registered select and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs       <= 1'b0;
            port_off <= '0;
        end else begin
            cs       <= hit;
            port_off <= offset;
        end
    end

    isa_io16_gen u_io16 (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_hit  (word_hit),
        .io_act    (io_act),
        .late_mode (mode_io16),
        .io16_n    (io16_n)
    );

    isa_wait_ctl u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .need_wait (need_wait),
        .io_act    (io_act),
        .mem_act   (mem_act),
        .bale      (bale),
        .isaclk    (isaclk),
        .early_en  (early_en),
        .chrdy_low (chrdy_low)
    );

    isa_late_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .io_act    (io_act),
        .need_wait (need_wait),
        .stat_clr  (stat_clr),
        .late_flag (late_flag)
    );

    // R2
    aen_blocks_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aen |=> !cs);

    // R2
    disabled_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_sel == 3'd7) |=> !cs && (port_off == '0));

    // R10
    both_modes_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_io16 && iord_n && iowr_n |=> !chrdy_low);

endmodule

// File: tb/isa_io_decoder_test.sv
module isa_io_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] sa = '0;
    logic       aen = 1'b1, bale = 1'b0;
    logic       iord_n = 1'b1, iowr_n = 1'b1, mrd_n = 1'b1, mwr_n = 1'b1;
    logic       isaclk = 1'b1, need_wait = 1'b0;
    logic [2:0] base_sel = '0;
    logic       mode_io16 = 1'b0, mode_chrdy = 1'b0, stat_clr = 1'b0;
    logic       cs, io16_n, chrdy_low, late_flag;
    logic [4:0] port_off;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    isa_io_decoder uut (
        .clk(clk), .rst_n(rst_n), .sa(sa), .aen(aen), .bale(bale),
        .iord_n(iord_n), .iowr_n(iowr_n), .mrd_n(mrd_n), .mwr_n(mwr_n),
        .isaclk(isaclk), .need_wait(need_wait), .base_sel(base_sel),
        .mode_io16(mode_io16), .mode_chrdy(mode_chrdy), .stat_clr(stat_clr),
        .cs(cs), .io16_n(io16_n), .chrdy_low(chrdy_low),
        .port_off(port_off), .late_flag(late_flag)
    );

    function automatic logic [9:0] exp_base(input int code);
        case (code)
            0: return 10'h240;
            1: return 10'h280;
            2: return 10'h2C0;
            3: return 10'h300;
            4: return 10'h320;
            5: return 10'h340;
            default: return 10'h360;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Inputs are changed after a falling edge. One rising edge follows, then
    // outputs are read at the next falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_bus();
        aen = 1'b1; bale = 1'b0; iord_n = 1'b1; iowr_n = 1'b1;
        mrd_n = 1'b1; mwr_n = 1'b1; need_wait = 1'b0; isaclk = 1'b1;
        mode_io16 = 1'b0; mode_chrdy = 1'b0; stat_clr = 1'b0; base_sel = 3'd0;
        step();
    endtask

    task automatic t_reset();
        chk("R2", "reset cs", cs, 0);
        chk("R3", "reset io16_n", io16_n, 1);
        chk("R5", "reset chrdy_low", chrdy_low, 0);
        chk("R9", "reset late_flag", late_flag, 0);
    endtask

    task automatic t_decode();
        for (int code = 0; code < 7; code++) begin
            base_sel = 3'(code); aen = 1'b0;
            sa = exp_base(code) + 10'h05; step();
            chk("R1", "cs in window", cs, 1);
            chk("R1", "port_off", port_off, 5);
            sa = exp_base(code) + 10'h1F; step();
            chk("R1", "port_off top", port_off, 31);
            sa = exp_base(code) + 10'h20; step();
            chk("R1", "cs above window", cs, 0);
            sa = exp_base(code) + 10'h03; aen = 1'b1; step();
            chk("R2", "cs with aen", cs, 0);
            chk("R2", "port_off with aen", port_off, 0);
        end
        base_sel = 3'd7; aen = 1'b0; sa = 10'h365; step();
        chk("R2", "cs with code 7", cs, 0);
        idle_bus();
    endtask

    task automatic t_io16_std();
        base_sel = 3'd3; aen = 1'b0; sa = 10'h310; step();
        chk("R3", "io16_n word port 10h", io16_n, 0);
        sa = 10'h317; step();
        chk("R3", "io16_n word port 17h", io16_n, 0);
        sa = 10'h318; step();
        chk("R3", "io16_n byte port 18h", io16_n, 1);
        sa = 10'h305; step();
        chk("R3", "io16_n byte port 05h", io16_n, 1);
        idle_bus();
    endtask

    task automatic t_io16_late();
        mode_io16 = 1'b1; base_sel = 3'd0; aen = 1'b0; sa = 10'h252; step();
        chk("R4", "io16_n no strobe", io16_n, 1);
        iord_n = 1'b0; step();
        chk("R4", "io16_n with iord", io16_n, 0);
        iord_n = 1'b1; iowr_n = 1'b0; step();
        chk("R4", "io16_n with iowr", io16_n, 0);
        iowr_n = 1'b1; step();
        chk("R4", "io16_n after strobe", io16_n, 1);
        mode_chrdy = 1'b1; need_wait = 1'b1; bale = 1'b1; step();
        chk("R10", "no early wait with both modes", chrdy_low, 0);
        chk("R10", "io16_n both modes no strobe", io16_n, 1);
        bale = 1'b0; iord_n = 1'b0; step();
        chk("R10", "io16_n both modes strobe", io16_n, 0);
        iord_n = 1'b1; need_wait = 1'b0; step();
        stat_clr = 1'b1; step();
        idle_bus();
    endtask

    task automatic t_wait_std();
        base_sel = 3'd5; aen = 1'b0; sa = 10'h344; need_wait = 1'b1; step();
        chk("R5", "no wait before strobe", chrdy_low, 0);
        bale = 1'b1; step();
        chk("R5", "no wait on bale in standard mode", chrdy_low, 0);
        bale = 1'b0; iowr_n = 1'b0; step();
        chk("R5", "wait with strobe and need", chrdy_low, 1);
        need_wait = 1'b0; step();
        chk("R5", "wait released when need drops", chrdy_low, 0);
        iowr_n = 1'b1; step();
        chk("R9", "strobe end with need 0 leaves flag", late_flag, 0);
        sa = 10'h044; need_wait = 1'b1; iord_n = 1'b0; step();
        chk("R5", "no wait outside window", chrdy_low, 0);
        idle_bus();
    endtask

    task automatic t_wait_early();
        mode_chrdy = 1'b1; base_sel = 3'd1; aen = 1'b0; sa = 10'h290;
        need_wait = 1'b1; isaclk = 1'b1; step();
        chk("R6", "no wait before bale", chrdy_low, 0);
        bale = 1'b1; step();
        chk("R6", "early wait on bale", chrdy_low, 1);
        isaclk = 1'b0; step();
        chk("R6", "isaclk fall during bale ignored", chrdy_low, 1);
        isaclk = 1'b1; step();
        bale = 1'b0; step();
        chk("R6", "held after bale falls", chrdy_low, 1);
        step();
        chk("R6", "held until isaclk falls", chrdy_low, 1);
        isaclk = 1'b0; step();
        chk("R6", "released at isaclk fall", chrdy_low, 0);
        isaclk = 1'b1; step();
        bale = 1'b1; step();
        chk("R7", "early wait again", chrdy_low, 1);
        mrd_n = 1'b0; step();
        chk("R7", "released by mrd", chrdy_low, 0);
        mrd_n = 1'b1; step();
        chk("R7", "no restart while bale high", chrdy_low, 0);
        bale = 1'b0; step();
        step();
        bale = 1'b1; step();
        chk("R7", "early wait third time", chrdy_low, 1);
        bale = 1'b0; step();
        mwr_n = 1'b0; step();
        chk("R7", "released by mwr after bale fell", chrdy_low, 0);
        idle_bus();
    endtask

    task automatic t_late_flag();
        base_sel = 3'd6; aen = 1'b0; sa = 10'h371; need_wait = 1'b1;
        iord_n = 1'b0; step();
        chk("R5", "wait during read", chrdy_low, 1);
        chk("R8", "flag not set while strobe", late_flag, 0);
        iord_n = 1'b1; step();
        chk("R8", "flag set on early strobe end", late_flag, 1);
        need_wait = 1'b0; sa = 10'h000; aen = 1'b1; step();
        step();
        chk("R9", "flag sticky", late_flag, 1);
        stat_clr = 1'b1; step();
        chk("R9", "flag cleared by write", late_flag, 0);
        stat_clr = 1'b0; step();
        chk("R9", "flag stays clear", late_flag, 0);
        idle_bus();
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_decode();
        t_io16_std();
        t_io16_late();
        t_wait_std();
        t_wait_early();
        t_late_flag();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule